// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Residue Output

This block sits in the feedback path of a digital PLL. It counts the rollover pulses of the numerically controlled oscillator and emits one output edge every S+1+U/V rollovers on average. To reach a fractional ratio it switches between two integer moduli, S+1 and S+2. A fractional accumulator chooses the modulus for each period. Every output edge carries a residue word. This word gives the exact, deterministic amount by which that edge comes early against an ideal fractional divider, in units of 1/V of a rollover period. The phase detector downstream can subtract the residue, so the dithering error is cancelled numerically rather than shaped into noise.

Settings arrive on S, U and V with a one-cycle load strobe. A settings state machine holds accepted values until the next output edge. It has two states. In ST_IDLE nothing is pending. In ST_ARMED a validated set is waiting. Four transitions are named. ACCEPT (ST_IDLE to ST_ARMED) happens on a valid load. REPLACE (ST_ARMED to ST_ARMED) happens on a valid load, with or without an edge in the same cycle. COMMIT (ST_ARMED to ST_IDLE) happens on an edge with no valid load in that cycle. HOLD keeps the present state in every other case. At COMMIT the pending set becomes active and the fractional accumulator is cleared. Invalid loads are dropped.

Top module: `frac_fb_divider`

## Requirements
- R1: After reset edge_o is 0 and residue_o is 0. The active settings are S=7, U=0 and V=1, so the block divides by 8.
- R2: edge_o is a one-cycle pulse in the clock cycle after the rollover that completes a period. Only cycles with roll_i high count, so idle cycles between rollovers do not change the edge positions in rollovers.
- R3: With U=0, an edge occurs every S+1 rollovers and residue_o is 0 on every edge.
- R4: From the point where settings take effect (accumulator at 0), the k-th edge closes exactly k*(S+1)+floor(k*U/V) rollovers later.
- R5: The residue on the k-th edge of R4 is (k*U) mod V. This is how far, in units of 1/V rollover, the edge comes before the ideal fractional position.
- R6: An accepted load takes effect at the next output edge. That edge still closes with the old ratio and reports residue 0. The accumulator restarts from 0.
- R7: A load with V=0, with U>=V, or with S<7 is ignored. Neither the pending nor the active settings change.
- R8: A second valid load before the next edge replaces the first. Only the latest set is committed.
- R9: A valid load in the same cycle as an edge-completing rollover is not used for that edge. It takes effect at the edge after.
- R10: edge_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| roll_i | input | 1 | NCO rollover pulse, one per rollover |
| load_i | input | 1 | Load strobe for s_i, u_i and v_i |
| s_i | input | 30 | Integer setting S |
| u_i | input | 10 | Fraction numerator U |
| v_i | input | 10 | Fraction denominator V |
| edge_o | output | 1 | Divided output edge pulse |
| residue_o | output | 10 | Residue of the latest edge, in 1/V rollover units |

## Verification
Two of the block's functions can fall in the same cycle: a settings load and the rollover that closes a period. The bench raises load_i together with the very roll_i pulse that completes a period. It then checks that this edge and the next one still follow the old ratio. The new ratio must govern only from the second edge on, and that second edge must report residue 0. A separate case issues two valid loads inside one period. Only the later load may shape the sequence after the commit.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
    parameter int S_W   = 30;
    parameter int F_W   = 10;
    parameter int S_MIN = 7;
    localparam int CNT_W = S_W + 1;

    typedef struct packed {
        logic [S_W-1:0] s;
        logic [F_W-1:0] u;
        logic [F_W-1:0] v;
    } ffd_set_t;

    typedef enum logic {
        ST_IDLE,
        ST_ARMED
    } ffd_state_e;

    localparam ffd_set_t SET_DEFAULT = '{s: S_W'(S_MIN), u: '0, v: F_W'(1)};
endpackage

// File: rtl/ffd_settings.sv
module ffd_settings
    import ffd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [S_W-1:0] s_i,
    input  logic [F_W-1:0] u_i,
    input  logic [F_W-1:0] v_i,
    input  logic           hit_i,
    output ffd_set_t       act_o,
    output logic           commit_o
);
    ffd_state_e state_q, state_d;
    ffd_set_t   pend_q;
    ffd_set_t   act_q;
    logic       load_ok;

    // validity screen for a new set
    assign load_ok = load_i && (v_i != '0) && (u_i < v_i) && (s_i >= S_W'(S_MIN));
    assign commit_o = hit_i && (state_q == ST_ARMED);
    assign act_o = act_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ACCEPT, REPLACE, COMMIT, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_ok) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (hit_i && !load_ok) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= SET_DEFAULT;
            act_q  <= SET_DEFAULT;
        end else begin
            if (commit_o) begin
                act_q <= pend_q;
            end
            if (load_ok) begin
                pend_q <= '{s: s_i, u: u_i, v: v_i};
            end
        end
    end

    AST_ACT_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> $past(hit_i)); // R6

    AST_ACT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.v != '0) && (act_q.u < act_q.v) && (act_q.s >= S_W'(S_MIN))); // R7
endmodule

// File: rtl/ffd_frac_acc.sv
module ffd_frac_acc
    import ffd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit_i,
    input  logic           commit_i,
    input  logic [F_W-1:0] u_i,
    input  logic [F_W-1:0] v_i,
    output logic           extra_o,
    output logic [F_W-1:0] residue_o
);
    logic [F_W-1:0] acc_q;
    logic [F_W:0]   sum;
    logic [F_W:0]   wrapped;

    // look ahead: does the period now running end with a carry?
    assign sum     = {1'b0, acc_q} + {1'b0, u_i};
    assign extra_o = (sum >= {1'b0, v_i});
    assign wrapped = extra_o ? (sum - {1'b0, v_i}) : sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            residue_o <= '0;
        end else if (hit_i) begin
            if (commit_i) begin
                acc_q     <= '0;
                residue_o <= '0;
            end else begin
                acc_q     <= wrapped[F_W-1:0];
                residue_o <= wrapped[F_W-1:0];
            end
        end
    end

    AST_ACC_BELOW_V: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < v_i); // R5

    AST_RES_ZERO_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && u_i == '0) |=> (residue_o == '0)); // R3
endmodule

// File: rtl/ffd_modcnt.sv
module ffd_modcnt
    import ffd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           roll_i,
    input  logic [S_W-1:0] s_i,
    input  logic           extra_i,
    output logic           hit_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // period is S+1 or S+2 rollovers; last index is S or S+1
    assign last_cnt = {1'b0, s_i} + CNT_W'(extra_i);
    assign hit_o    = roll_i && (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hit_o) begin
            cnt_q <= '0;
        end else if (roll_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !roll_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/frac_fb_divider.sv
module frac_fb_divider
    import ffd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           roll_i,
    input  logic           load_i,
    input  logic [S_W-1:0] s_i,
    input  logic [F_W-1:0] u_i,
    input  logic [F_W-1:0] v_i,
    output logic           edge_o,
    output logic [F_W-1:0] residue_o
);
    ffd_set_t act;
    logic     hit;
    logic     commit;
    logic     extra;

    ffd_settings u_settings (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .s_i      (s_i),
        .u_i      (u_i),
        .v_i      (v_i),
        .hit_i    (hit),
        .act_o    (act),
        .commit_o (commit)
    );

    ffd_frac_acc u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .commit_i  (commit),
        .u_i       (act.u),
        .v_i       (act.v),
        .extra_o   (extra),
        .residue_o (residue_o)
    );

    ffd_modcnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .roll_i  (roll_i),
        .s_i     (act.s),
        .extra_i (extra),
        .hit_o   (hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_o <= 1'b0;
        end else begin
            edge_o <= hit;
        end
    end

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R10

    AST_EDGE_FOLLOWS_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> $past(roll_i)); // R2
endmodule

// File: tb/frac_fb_divider_tb.sv
module frac_fb_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        roll_i = 1'b0;
    logic        load_i = 1'b0;
    logic [29:0] s_i = '0;
    logic [9:0]  u_i = '0;
    logic [9:0]  v_i = '0;
    logic        edge_o;
    logic [9:0]  residue_o;

    int total = 0;
    int bad = 0;
    int ne;
    int epos [MAXE];
    int eres [MAXE];

    frac_fb_divider dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .roll_i    (roll_i),
        .load_i    (load_i),
        .s_i       (s_i),
        .u_i       (u_i),
        .v_i       (v_i),
        .edge_o    (edge_o),
        .residue_o (residue_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_load(input int s, input int u, input int v);
        @(negedge clk);
        roll_i = 1'b0;
        load_i = 1'b1;
        s_i = 30'(s); u_i = 10'(u); v_i = 10'(v);
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // drive n rollovers; record edges; optional load on rollover load_at
    task automatic run(input int n, input bit gap, input int load_at,
                       input int ls, input int lu, input int lv);
        int  rolls = 0;
        bit  gap_ph = 1'b0;
        bit  prev = 1'b0;
        ne = 0;
        while (1) begin
            @(negedge clk);
            if (edge_o) begin
                if (ne < MAXE) begin
                    epos[ne] = rolls;
                    eres[ne] = int'(residue_o);
                end
                ne++;
            end
            if (prev && edge_o) chk(1'b0, "R10", "edge in consecutive cycles", 1, 0);
            prev = edge_o;
            if (rolls == n) begin
                roll_i = 1'b0;
                load_i = 1'b0;
                break;
            end
            if (gap && !gap_ph) begin
                roll_i = 1'b0;
                load_i = 1'b0;
                gap_ph = 1'b1;
            end else begin
                roll_i = 1'b1;
                rolls++;
                gap_ph = 1'b0;
                load_i = (rolls == load_at);
                if (rolls == load_at) begin
                    s_i = 30'(ls); u_i = 10'(lu); v_i = 10'(lv);
                end
            end
        end
    endtask

    // check edges first..first+cnt-1 as a fresh sequence starting at base
    task automatic chk_seq(input int first, input int cnt, input int base,
                           input int s, input int u, input int v, input string req);
        for (int k = 1; k <= cnt; k++) begin
            int idx = first + k - 1;
            int ep = base + k * (s + 1) + (k * u) / v;
            int er = (k * u) % v;
            chk(epos[idx] == ep, req, "edge position", epos[idx], ep);
            chk(eres[idx] == er, req, "edge residue", eres[idx], er);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(edge_o == 1'b0, "R1", "edge after reset", int'(edge_o), 0);
        chk(residue_o == '0, "R1", "residue after reset", int'(residue_o), 0);
    endtask

    task automatic t_integer();
        run(24, 1'b0, -1, 0, 0, 0);
        chk(ne == 3, "R3", "edge count default", ne, 3);
        chk_seq(0, 3, 0, 7, 0, 1, "R3");
        run(16, 1'b1, -1, 0, 0, 0);
        chk(ne == 2, "R2", "edge count with idle gaps", ne, 2);
        chk_seq(0, 2, 0, 7, 0, 1, "R2");
    endtask

    task automatic t_fraction();
        do_load(9, 3, 7);
        run(81, 1'b0, -1, 0, 0, 0);
        chk(ne == 8, "R4", "edge count fractional", ne, 8);
        chk(epos[0] == 8, "R6", "commit edge keeps old ratio", epos[0], 8);
        chk(eres[0] == 0, "R6", "commit edge residue", eres[0], 0);
        chk_seq(1, 7, 8, 9, 3, 7, "R4 R5");
    endtask

    task automatic t_reject();
        do_load(9, 3, 0);
        do_load(9, 5, 5);
        do_load(6, 3, 7);
        run(73, 1'b0, -1, 0, 0, 0);
        chk(ne == 7, "R7", "edge count after bad loads", ne, 7);
        chk_seq(0, 7, 0, 9, 3, 7, "R7");
    endtask

    task automatic t_replace();
        do_load(7, 1, 2);
        do_load(8, 0, 1);
        run(28, 1'b0, -1, 0, 0, 0);
        chk(ne == 3, "R8", "edge count after replace", ne, 3);
        chk(epos[0] == 10 && eres[0] == 0, "R8", "commit edge position", epos[0], 10);
        chk_seq(1, 2, 10, 8, 0, 1, "R8");
    endtask

    task automatic t_same_cycle();
        run(43, 1'b0, 9, 7, 1, 3);
        chk(ne == 5, "R9", "edge count load on edge", ne, 5);
        chk(epos[0] == 9 && eres[0] == 0, "R9", "edge with coincident load", epos[0], 9);
        chk(epos[1] == 18, "R9", "commit edge position", epos[1], 18);
        chk(eres[1] == 0, "R9", "commit edge residue", eres[1], 0);
        chk_seq(2, 3, 18, 7, 1, 3, "R9");
    endtask

    task automatic t_wide_fraction();
        do_load(7, 1022, 1023);
        run(43, 1'b0, -1, 0, 0, 0);
        chk(ne == 5, "R5", "edge count wide fraction", ne, 5);
        chk(epos[0] == 8 && eres[0] == 0, "R6", "commit edge", epos[0], 8);
        chk_seq(1, 4, 8, 7, 1022, 1023, "R5");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_integer();
        t_fraction();
        t_reject();
        t_replace();
        t_same_cycle();
        t_wide_fraction();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule